// File: doc/BRIEF.md
# Stack Block-Transfer Sequencer

This block performs multi-register stack saves and restores over a word-wide memory port. Software-visible behaviour is selected with three inputs. The first is an 8-bit mask of low registers, indices 0 to 7. The second is one extra-register bit. The third is the direction. On a start pulse the block takes a snapshot of the current stack pointer. It then steps through the selected registers one word access at a time. When it finishes, it hands back the new stack pointer.

A save (`startPop` = 0) reads values from a register-file read port and writes them to memory. Its region begins at SP − 4·N, where N is the number of set mask bits plus the extra bit. A restore (`startPop` = 1) reads memory from SP upward and writes each word to a register-file write port.

Registers move in ascending index order to ascending word addresses. The extra register is always the last transfer, at the highest address. On a save it is the link register (index 14). On a restore it is the program counter (index 15).

If a memory response carries an error, the operation stops immediately and an abort is reported.

Top module: `stack_burst_seq`

## Requirements
- R1: After reset, `busy`, `done`, `abortOut`, `spWe`, `memReq` and `rfWe` are all 0.
- R2: A restore issues reads (`memWe` = 0) starting at the snapshot SP, stepping by 4 per beat. Each read word is written to the selected registers in ascending index order. With the extra bit set, index 15 is loaded last.
- R3: A save issues writes (`memWe` = 1) starting at SP − 4·N, stepping by 4 per beat. The data is `rfRdData` for `rfRdIdx` in ascending index order. With the extra bit set, index 14 is stored last at the highest address. No register-file write occurs.
- R4: On completion, `spWe` and `done` are high for one cycle. `spOut` is SP + 4·N for a restore and SP − 4·N for a save.
- R5: A request stays asserted with unchanged address until `memReady`. A beat completes only on a cycle where both are high.
- R6: A response with `memErr` high ends the operation. That beat writes no register, no further request is made, and `spWe` and `done` stay low. `abortOut` is high for one cycle on the next cycle, when `busy` is already low.
- R7: An empty mask with the extra bit clear makes no memory access and does not assert `spWe`. It still pulses `done`, with `busy` high for exactly one cycle.
- R8: When index 15 is loaded with a word whose bits [1:0] are 2'b10, `badTarget` is high in that write cycle. Any other loaded value leaves `badTarget` low.
- R9: A start pulse while `busy` is high is ignored.
- R10: `busy` rises the cycle after an accepted start and stays high through the `done` cycle. Without wait states it lasts N+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| startPop | input | 1 | 1 = restore from stack, 0 = save to stack |
| regMask | input | 8 | Low-register selection, bit i = register i |
| extraReg | input | 1 | Include link register (save) or program counter (restore) |
| spIn | input | 32 | Current stack pointer, word aligned |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| abortOut | output | 1 | One-cycle pulse after an error response |
| spWe | output | 1 | Stack pointer write strobe |
| spOut | output | 32 | Updated stack pointer |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Byte address of the word |
| memWdata | output | 32 | Write data |
| memReady | input | 1 | Access accepted this cycle |
| memErr | input | 1 | Error on the accepted access |
| memRdata | input | 32 | Read data, valid with memReady |
| rfRdIdx | output | 4 | Register-file read index |
| rfRdData | input | 32 | Register-file read data (combinational) |
| rfWe | output | 1 | Register-file write strobe |
| rfWrIdx | output | 4 | Register-file write index |
| rfWrData | output | 32 | Register-file write data |
| badTarget | output | 1 | Program counter loaded with a misaligned target |

## Verification
The checks assume several things about the inputs. `spIn` is word aligned whenever `start` is sampled. `rfRdData` follows `rfRdIdx` combinationally, so held write data is stable while a request waits. `memErr` is meaningful only together with `memReady`.

The stimulus respects these assumptions:
- Every stack pointer it supplies is a multiple of four.
- The register-file model is a plain combinational array that changes only on restore beats.
- The memory responder raises `memErr` only on a request cycle, at a chosen beat number.
- Wait states are injected by alternating `memReady`, so the hold behaviour is exercised without breaking these rules.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic load;     // capture request and stack pointer
    logic advance;  // retire the current beat
  } seq_strobes_t;

endpackage

// File: rtl/stack_seq_dp.sv
module stack_seq_dp
  import stack_seq_pkg::*;
#(
  parameter int LIST_W     = 8,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 4,
  parameter int LINK_IDX   = 14,
  parameter int PC_IDX     = 15,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobes_t      strb,
  input  logic              startPop,
  input  logic [LIST_W-1:0] regMask,
  input  logic              extraReg,
  input  logic [ADDR_W-1:0] spIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [IDX_W-1:0]  curIdx,
  output logic              opPop,
  output logic              reqEmpty,
  output logic              opEmpty,
  output logic              lastBeat,
  output logic [ADDR_W-1:0] spNext,
  output logic              pcMisalignedRaw
);

  localparam int SEL_W      = LIST_W + 1;
  localparam int CNT_W      = $clog2(SEL_W + 1);
  localparam int WORD_SHIFT = $clog2(WORD_BYTES);

  logic [SEL_W-1:0]  reqSel;
  logic [CNT_W-1:0]  reqCnt;
  logic [ADDR_W-1:0] reqSpan;
  logic [SEL_W-1:0]  selQ;
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] spQ;
  logic [CNT_W-1:0]  cntQ;
  logic              popQ;
  logic [ADDR_W-1:0] opSpan;

  assign reqSel   = {extraReg, regMask};
  assign reqCnt   = CNT_W'($countones(reqSel));
  assign reqSpan  = ADDR_W'(reqCnt) << WORD_SHIFT;
  assign reqEmpty = (reqSel == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ  <= '0;
      addrQ <= '0;
      spQ   <= '0;
      cntQ  <= '0;
      popQ  <= 1'b0;
    end else if (strb.load) begin
      selQ  <= reqSel;
      spQ   <= spIn;
      cntQ  <= reqCnt;
      popQ  <= startPop;
      addrQ <= startPop ? spIn : (spIn - reqSpan);
    end else if (strb.advance) begin
      selQ  <= selQ & (selQ - SEL_W'(1));
      addrQ <= addrQ + ADDR_W'(WORD_BYTES);
    end
  end

  // lowest set bit of the remaining selection picks the register
  always_comb begin
    curIdx = '0;
    for (int i = SEL_W - 1; i >= 0; i--) begin
      if (selQ[i]) begin
        if (i == LIST_W) curIdx = popQ ? IDX_W'(PC_IDX) : IDX_W'(LINK_IDX);
        else             curIdx = IDX_W'(i);
      end
    end
  end

  assign lastBeat = ((selQ & (selQ - SEL_W'(1))) == '0);
  assign opEmpty  = (cntQ == '0);
  assign opPop    = popQ;
  assign memAddr  = addrQ;
  assign opSpan   = ADDR_W'(cntQ) << WORD_SHIFT;
  assign spNext   = popQ ? (spQ + opSpan) : (spQ - opSpan);
  assign pcMisalignedRaw = popQ && (curIdx == IDX_W'(PC_IDX)) && (memRdata[1:0] == 2'b10);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> (addrQ == $past(addrQ) + ADDR_W'(WORD_BYTES))); // R2

endmodule

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         reqEmpty,
  input  logic         opEmpty,
  input  logic         lastBeat,
  input  logic         opPop,
  input  logic         memReady,
  input  logic         memErr,
  output seq_strobes_t strb,
  output logic         busy,
  output logic         done,
  output logic         abortOut,
  output logic         spWe,
  output logic         memReq,
  output logic         rfWe
);

  seq_state_t state, nxt;
  logic abortQ;

  always_comb begin
    nxt    = state;
    strb   = '0;
    memReq = 1'b0;
    rfWe   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          nxt = reqEmpty ? ST_DONE : ST_XFER;
        end
      end
      ST_XFER: begin
        memReq = 1'b1;
        if (memReady) begin
          if (memErr) begin
            nxt = ST_IDLE;
          end else begin
            strb.advance = 1'b1;
            rfWe = opPop;
            if (lastBeat) nxt = ST_DONE;
          end
        end
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      abortQ <= 1'b0;
    end else begin
      state  <= nxt;
      abortQ <= (state == ST_XFER) && memReady && memErr;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);
  assign spWe     = (state == ST_DONE) && !opEmpty;
  assign abortOut = abortQ;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> memReq); // R5
  AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady && memErr) |=> (abortOut && !busy && !spWe && !done)); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!busy && !done)); // R10
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R10

endmodule

// File: rtl/stack_burst_seq.sv
module stack_burst_seq
  import stack_seq_pkg::*;
#(
  parameter int LIST_W     = 8,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 4,
  parameter int LINK_IDX   = 14,
  parameter int PC_IDX     = 15,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              startPop,
  input  logic [LIST_W-1:0] regMask,
  input  logic              extraReg,
  input  logic [ADDR_W-1:0] spIn,
  output logic              busy,
  output logic              done,
  output logic              abortOut,
  output logic              spWe,
  output logic [ADDR_W-1:0] spOut,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memReady,
  input  logic              memErr,
  input  logic [DATA_W-1:0] memRdata,
  output logic [IDX_W-1:0]  rfRdIdx,
  input  logic [DATA_W-1:0] rfRdData,
  output logic              rfWe,
  output logic [IDX_W-1:0]  rfWrIdx,
  output logic [DATA_W-1:0] rfWrData,
  output logic              badTarget
);

  seq_strobes_t     strb;
  logic             reqEmpty, opEmpty, lastBeat, opPop, pcMisalignedRaw;
  logic [IDX_W-1:0] curIdx;

  stack_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .reqEmpty(reqEmpty), .opEmpty(opEmpty), .lastBeat(lastBeat), .opPop(opPop),
    .memReady(memReady), .memErr(memErr),
    .strb(strb), .busy(busy), .done(done), .abortOut(abortOut),
    .spWe(spWe), .memReq(memReq), .rfWe(rfWe)
  );

  stack_seq_dp #(
    .LIST_W(LIST_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .LINK_IDX(LINK_IDX), .PC_IDX(PC_IDX), .WORD_BYTES(WORD_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .startPop(startPop), .regMask(regMask), .extraReg(extraReg), .spIn(spIn),
    .memRdata(memRdata), .memAddr(memAddr), .curIdx(curIdx), .opPop(opPop),
    .reqEmpty(reqEmpty), .opEmpty(opEmpty), .lastBeat(lastBeat),
    .spNext(spOut), .pcMisalignedRaw(pcMisalignedRaw)
  );

  assign memWe     = memReq && !opPop;
  assign memWdata  = rfRdData;
  assign rfRdIdx   = curIdx;
  assign rfWrIdx   = curIdx;
  assign rfWrData  = memRdata;
  assign badTarget = rfWe && pcMisalignedRaw;

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> ($stable(memAddr) && $stable(memWe))); // R5
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00)); // R2
  AST_RF_WRITE_POP_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    rfWe |-> (memReq && !memWe && memReady)); // R3
  AST_BAD_TARGET_PC: assert property (@(posedge clk) disable iff (!rstN)
    badTarget |-> (rfWe && rfWrIdx == IDX_W'(PC_IDX) && rfWrData[1:0] == 2'b10)); // R8

endmodule

// File: tb/stack_burst_seq_bench.sv
`timescale 1ns/1ps
module stack_burst_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, startPop = 1'b0, extraReg = 1'b0;
  logic [7:0]  regMask = '0;
  logic [31:0] spIn = '0;
  logic        busy, done, abortOut, spWe, memReq, memWe, rfWe, badTarget;
  logic [31:0] spOut, memAddr, memWdata, memRdata, rfRdData, rfWrData;
  logic [3:0]  rfRdIdx, rfWrIdx;
  logic        memReady = 1'b0, memErr = 1'b0;

  logic [31:0] mem [0:255];
  logic [31:0] rf  [0:15];
  assign memRdata = mem[memAddr[9:2]];
  assign rfRdData = rf[rfRdIdx];

  int nChk = 0, nFail = 0;
  int nAcc, nRfw, nSp, nDone, nAbort, nBad, busyCyc, reqCyc, errBeat;
  logic [31:0] spVal;
  logic [31:0] accAddr [0:31];
  logic        accWe   [0:31];
  logic [3:0]  rfwIdx  [0:31];
  bit stallMode = 0, phase = 0;

  stack_burst_seq u_stack_burst_seq (
    .clk(clk), .rstN(rstN), .start(start), .startPop(startPop), .regMask(regMask),
    .extraReg(extraReg), .spIn(spIn), .busy(busy), .done(done), .abortOut(abortOut),
    .spWe(spWe), .spOut(spOut), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memReady(memReady), .memErr(memErr), .memRdata(memRdata),
    .rfRdIdx(rfRdIdx), .rfRdData(rfRdData), .rfWe(rfWe), .rfWrIdx(rfWrIdx),
    .rfWrData(rfWrData), .badTarget(badTarget)
  );

  always #2.5 clk = ~clk;

  // memory responder: decides ready/err shortly after each rising edge
  always @(posedge clk) begin
    #1;
    if (memReq) phase = ~phase; else phase = 0;
    memReady = memReq && (!stallMode || !phase);
    memErr   = memReq && (nAcc == errBeat);
  end

  // monitor at the falling edge, where everything has settled
  always @(negedge clk) begin
    if (rstN) begin
      if (busy) busyCyc++;
      if (memReq) reqCyc++;
      if (memReq && memReady) begin
        if (nAcc < 32) begin accAddr[nAcc] = memAddr; accWe[nAcc] = memWe; end
        if (memWe && !memErr) mem[memAddr[9:2]] = memWdata;
        nAcc++;
      end
      if (rfWe) begin
        if (nRfw < 32) rfwIdx[nRfw] = rfWrIdx;
        rf[rfWrIdx] = rfWrData;
        nRfw++;
      end
      if (spWe) begin nSp++; spVal = spOut; end
      if (done) nDone++;
      if (abortOut) nAbort++;
      if (badTarget) nBad++;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clearLog();
    nAcc = 0; nRfw = 0; nSp = 0; nDone = 0; nAbort = 0; nBad = 0;
    busyCyc = 0; reqCyc = 0; spVal = '0;
  endtask

  task automatic pulseStart(input bit pop, input logic [7:0] mask, input bit r, input logic [31:0] sp);
    @(posedge clk); #1;
    start = 1; startPop = pop; regMask = mask; extraReg = r; spIn = sp;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic waitEnd();
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (nDone + nAbort > 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic runOp(input bit pop, input logic [7:0] mask, input bit r, input logic [31:0] sp);
    clearLog();
    pulseStart(pop, mask, r, sp);
    waitEnd();
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "memReq", 32'(memReq), 0);
    chk("R1", "spWe/rfWe/done/abort", {28'd0, spWe, rfWe, done, abortOut}, 0);
  endtask

  task automatic testPopBasic();
    mem[64] = 32'hA000_0000; mem[65] = 32'hA000_0002; mem[66] = 32'hA000_0005;
    runOp(1, 8'h25, 0, 32'h100);
    chk("R2", "accesses", nAcc, 3);
    chk("R2", "addr0", accAddr[0], 32'h100);
    chk("R2", "addr2", accAddr[2], 32'h108);
    chk("R2", "read dir", {31'd0, accWe[1]}, 0);
    chk("R2", "reg order", {rfwIdx[0], rfwIdx[1], rfwIdx[2]}, {4'd0, 4'd2, 4'd5});
    chk("R2", "r5 value", rf[5], 32'hA000_0005);
    chk("R4", "sp out", spVal, 32'h10C);
    chk("R4", "sp writes/done", {nSp[15:0], nDone[15:0]}, {16'd1, 16'd1});
    chk("R10", "busy cycles", busyCyc, 4);
  endtask

  task automatic testPopPc();
    mem[96] = 32'h1; mem[97] = 32'h7; mem[98] = 32'h0000_2004;
    runOp(1, 8'h81, 1, 32'h180);
    chk("R2", "pc last idx", {28'd0, rfwIdx[2]}, 15);
    chk("R2", "pc value", rf[15], 32'h0000_2004);
    chk("R8", "no bad target", nBad, 0);
    chk("R4", "sp out", spVal, 32'h18C);
    mem[112] = 32'h0000_3002;
    runOp(1, 8'h00, 1, 32'h1C0);
    chk("R8", "bad target flagged", nBad, 1);
    chk("R8", "pc still written", rf[15], 32'h0000_3002);
    chk("R4", "sp out pc only", spVal, 32'h1C4);
  endtask

  task automatic testPush();
    rf[1] = 32'h1111_1111; rf[3] = 32'h3333_3333; rf[14] = 32'hEEEE_0000;
    runOp(0, 8'h0A, 1, 32'h200);
    chk("R3", "accesses", nAcc, 3);
    chk("R3", "start addr", accAddr[0], 32'h1F4);
    chk("R3", "write dir", {31'd0, accWe[0]}, 1);
    chk("R3", "mem r1", mem[125], 32'h1111_1111);
    chk("R3", "mem r3", mem[126], 32'h3333_3333);
    chk("R3", "link top", mem[127], 32'hEEEE_0000);
    chk("R3", "no rf write", nRfw, 0);
    chk("R4", "sp out", spVal, 32'h1F4);
  endtask

  task automatic testPushStall();
    for (int i = 0; i < 8; i++) rf[i] = 32'hC0DE_0000 + 32'(i);
    stallMode = 1;
    runOp(0, 8'hFF, 0, 32'h300);
    stallMode = 0;
    chk("R5", "accesses", nAcc, 8);
    chk("R5", "request cycles", reqCyc, 16);
    chk("R5", "last addr", accAddr[7], 32'h2FC);
    chk("R3", "mem first", mem[184], 32'hC0DE_0000);
    chk("R3", "mem last", mem[191], 32'hC0DE_0007);
    chk("R4", "sp out", spVal, 32'h2E0);
  endtask

  task automatic testEmpty();
    runOp(1, 8'h00, 0, 32'h240);
    chk("R7", "no access", nAcc, 0);
    chk("R7", "no sp write", nSp, 0);
    chk("R7", "done", nDone, 1);
    chk("R7", "busy cycles", busyCyc, 1);
  endtask

  task automatic testError();
    rf[1] = 32'h5A5A_5A5A;
    errBeat = 1;
    runOp(1, 8'h0F, 0, 32'h140);
    errBeat = -1;
    chk("R6", "accesses", nAcc, 2);
    chk("R6", "rf writes", nRfw, 1);
    chk("R6", "r1 kept", rf[1], 32'h5A5A_5A5A);
    chk("R6", "no sp write", nSp, 0);
    chk("R6", "abort pulse", nAbort, 1);
    chk("R6", "no done", nDone, 0);
    chk("R6", "idle after", 32'(busy), 0);
  endtask

  task automatic testStartWhileBusy();
    stallMode = 1;
    clearLog();
    pulseStart(1, 8'h03, 0, 32'h100);
    @(posedge clk); #1;
    start = 1; startPop = 0; regMask = 8'hFF; extraReg = 1; spIn = 32'h380;
    @(posedge clk); #1;
    start = 0;
    waitEnd();
    repeat (10) @(negedge clk);
    stallMode = 0;
    chk("R9", "accesses", nAcc, 2);
    chk("R9", "still reads", {30'd0, accWe[0], accWe[1]}, 0);
    chk("R9", "one done", nDone, 1);
    chk("R9", "sp out", spVal, 32'h108);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  endtask

  initial begin
    #750000;
    nChk++; nFail++;
    $display("FAIL watchdog: run did not complete actual=hung expected=finished");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
    for (int i = 0; i < 16; i++) rf[i] = 32'h0;
    errBeat = -1;
    clearLog();
    repeat (4) @(posedge clk);
    #1 rstN = 1;
    testReset();
    testPopBasic();
    testPopPc();
    testPush();
    testPushStall();
    testEmpty();
    testError();
    testStartWhileBusy();
    finishRun();
  end

endmodule